// File: doc/BRIEF.md
# Management Controller Command/Data Port Status Engine

This block is the device side of a byte-wide port pair on a system management controller. The host talks to it through two addresses. One is a command port: a write there starts a transaction, and a read there returns an 8-bit status register. The other is a data port, which carries the key bytes, the length byte and the payload in both directions. The status register paces the host. It shows when the controller is ready, when it is refusing input, when it is in the middle of a transaction, when the last byte was a command, and when a response byte is waiting to be read.

A transaction starts with a command byte. Four key bytes follow, then a length byte. A write command then takes that many payload bytes into a small internal key/value store. A read command instead presents that many bytes on the data port for the host to read back. After every byte it accepts, the controller closes its input for a programmable number of cycles. This models processing time. Any valid command byte restarts the transaction logic from whatever state it is in.

Top module: `mgmt_port_engine`

## Requirements
- R1: Status bit 6 (ready) reads 1 in every cycle. Bit 4 always reads 0. After reset the status is exactly 0x40.
- R2: With `port_sel`=1, a read returns the status register and a write is taken as a command byte. With `port_sel`=0, the data port is addressed. A data-port read outside the read phase returns 0x00.
- R3: After every accepted write, status bit 1 (input closed) is 1 for exactly HOLD_CYC cycles (default 2), starting at the clock edge that accepted the write. Any write to either port while bit 1 is set is ignored.
- R4: A command byte of 0x10 (read) or 0x11 (write), accepted in any state, sets bits 3 and 2, clears bits 0, 5 and 7, and restarts key collection at the first key byte.
- R5: A command is followed by four key bytes on the data port, most significant byte first, and then a length byte. A length above 32 is treated as 32.
- R6: Bit 2 (busy) stays set from the command byte until the final byte of the transaction and clears at that byte's edge. The final byte is the last payload byte written, the last response byte read, or the length byte when the length is 0. Bit 5 (key done) sets at the same edge.
- R7: Bit 3 (got command) clears when the first data-port write after the command is accepted.
- R8: In a read transaction, bit 0 is set together with bit 2 from the length byte until the last response byte is read. Each data-port read returns the byte at the current position and advances by one.
- R9: Any other command byte sets bit 7 (error) and returns to idle with bits 0, 2, 3 and 5 clear. The next valid command clears bit 7.
- R10: The store holds 8 keys of up to 32 bytes each. A read of a stored key returns the bytes written under it. Positions never written since the key was stored read as 0x00. A read of an unknown key returns 0x00 for every requested byte.
- R11: A write to a new key when all 8 entries are in use replaces the entry that was stored earliest. A write to a key already stored reuses its entry.
- R12: Data-port writes while idle or during the read phase are ignored. They do not change the transaction state and do not set bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed port |
| bus_rd | input | 1 | Read strobe for the addressed port |
| port_sel | input | 1 | 1 selects the command/status port, 0 selects the data port |
| bus_wdata | input | 8 | Byte being written |
| bus_rdata | output | 8 | Status (command port) or response byte (data port) |
| status_o | output | 8 | Live status register |

## Verification
The bench targets writes issued while input is closed. If the design accepted one of those, the key bytes would be misaligned and later read-backs would return the wrong bytes. It aborts a half-sent transaction with a fresh command. A design without resynchronisation would swallow the new key bytes as the tail of the old key. It also covers the zero-length and over-length cases, where a design that got the end condition wrong would leave busy stuck or stop short of 32 bytes. Finally it fills the store past eight keys, where a design with the wrong replacement order would either keep the first key or drop a recent one.

// File: rtl/mpe_pkg.sv
// Shared encodings for the management port status engine.
package mpe_pkg;
    // Command codes the engine accepts on the command port
    localparam logic [7:0] OP_READ  = 8'h10;
    localparam logic [7:0] OP_WRITE = 8'h11;

    // Status register bit positions
    localparam int SB_AWAIT  = 0;
    localparam int SB_CLOSED = 1;
    localparam int SB_BUSY   = 2;
    localparam int SB_GOTCMD = 3;
    localparam int SB_DONE   = 5;
    localparam int SB_READY  = 6;
    localparam int SB_ERR    = 7;

    // Transaction phase
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_KEY,
        PH_LEN,
        PH_WDATA,
        PH_RDATA
    } phase_e;
endpackage

// File: rtl/mpe_hold_timer.sv
// Input-closed timer.
// Reloads to HOLD_CYC on every accepted write and counts down to zero.
// The closed flag is high while the count is non-zero.
// Assumes load_i is already qualified by the caller (only accepted writes).
module mpe_hold_timer #(
    parameter int HOLD_CYC = 2,
    localparam int CNT_W = $clog2(HOLD_CYC + 2)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic closed_o
);
    logic [CNT_W-1:0] cnt_q;

    // Reload on an accepted byte, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= CNT_W'(HOLD_CYC);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    // Closed while the count is running
    assign closed_o = (cnt_q != '0);

    generate
        if (HOLD_CYC > 0) begin : g_chk
            // R3
            hold_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
                load_i |=> closed_o);
        end
    endgenerate
endmodule

// File: rtl/mpe_key_store.sv
// Key/value store.
// ENTRIES keys of KEY_W bits, each with MAX_LEN data bytes.
// Lookup is combinational over all valid keys.
// Allocation takes the slot after the previous allocation (oldest first),
// writes the key and clears that slot's data.
// Assumes alloc_i is raised only on a lookup miss.
module mpe_key_store #(
    parameter int ENTRIES = 8,
    parameter int MAX_LEN = 32,
    parameter int KEY_W   = 32,
    localparam int SLOT_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int BIDX_W = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [KEY_W-1:0]  look_key_i,
    output logic              hit_o,
    output logic [SLOT_W-1:0] hit_slot_o,
    input  logic              alloc_i,
    output logic [SLOT_W-1:0] alloc_slot_o,
    input  logic              wr_i,
    input  logic [SLOT_W-1:0] wr_slot_i,
    input  logic [BIDX_W-1:0] wr_idx_i,
    input  logic [7:0]        wr_byte_i,
    input  logic [SLOT_W-1:0] rd_slot_i,
    input  logic [BIDX_W-1:0] rd_idx_i,
    output logic [7:0]        rd_byte_o
);
    logic [KEY_W-1:0]  tag_q [ENTRIES];
    logic              vld_q [ENTRIES];
    logic [7:0]        mem_q [ENTRIES][MAX_LEN];
    logic [SLOT_W-1:0] ptr_q;

    // Parallel key match, lowest matching slot wins
    always_comb begin
        logic found;
        found      = 1'b0;
        hit_slot_o = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (!found && vld_q[e] && tag_q[e] == look_key_i) begin
                found      = 1'b1;
                hit_slot_o = SLOT_W'(e);
            end
        end
        hit_o = found;
    end

    assign alloc_slot_o = ptr_q;
    assign rd_byte_o    = mem_q[rd_slot_i][rd_idx_i];

    // Allocate keys in order and store payload bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            for (int e = 0; e < ENTRIES; e++) begin
                tag_q[e] <= '0;
                vld_q[e] <= 1'b0;
                for (int b = 0; b < MAX_LEN; b++)
                    mem_q[e][b] <= 8'h00;
            end
        end else begin
            if (alloc_i) begin
                tag_q[ptr_q] <= look_key_i;
                vld_q[ptr_q] <= 1'b1;
                for (int b = 0; b < MAX_LEN; b++)
                    mem_q[ptr_q][b] <= 8'h00;
                ptr_q <= (ptr_q == SLOT_W'(ENTRIES - 1)) ? '0 : ptr_q + SLOT_W'(1);
            end
            if (wr_i)
                mem_q[wr_slot_i][wr_idx_i] <= wr_byte_i;
        end
    end

    // R11
    alloc_only_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_i |-> !hit_o);

    // R10
    no_alloc_and_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(alloc_i && wr_i));
endmodule

// File: rtl/mpe_txn_fsm.sv
// Transaction state machine.
// Takes command and data-port bytes, tracks the phase (key, length,
// write payload, read response), and keeps the got-command, key-done and
// error flags. Drives the store's allocate/write strobes and the byte index.
// Assumes closed_i comes from the hold timer that this block loads via take_o.
module mpe_txn_fsm
    import mpe_pkg::*;
#(
    parameter int ENTRIES   = 8,
    parameter int MAX_LEN   = 32,
    parameter int KEY_BYTES = 4,
    localparam int KEY_W  = 8 * KEY_BYTES,
    localparam int SLOT_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int BIDX_W = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1,
    localparam int IDX_W  = $clog2(MAX_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              closed_i,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              cmd_sel,
    input  logic [7:0]        wdata,
    input  logic              hit_i,
    input  logic [SLOT_W-1:0] hit_slot_i,
    input  logic [SLOT_W-1:0] alloc_slot_i,
    output logic              take_o,
    output logic [KEY_W-1:0]  key_o,
    output logic              alloc_o,
    output logic              st_wr_o,
    output logic [SLOT_W-1:0] slot_o,
    output logic [BIDX_W-1:0] idx_o,
    output logic              hit_q_o,
    output phase_e            phase_o,
    output logic              gotcmd_o,
    output logic              done_o,
    output logic              err_o
);
    phase_e            phase_q;
    logic [IDX_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  len_q;
    logic [KEY_W-1:0]  key_q;
    logic [SLOT_W-1:0] slot_q;
    logic              is_wr_q, hit_q, gotcmd_q, done_q, err_q;

    logic             cmd_wr, dat_wr, dat_rd, op_ok, last;
    logic [IDX_W-1:0] len_in;

    // Qualify the bus strobes against the closed flag and the phase
    always_comb begin
        cmd_wr = wr_en && cmd_sel && !closed_i;
        dat_wr = wr_en && !cmd_sel && !closed_i &&
                 (phase_q == PH_KEY || phase_q == PH_LEN || phase_q == PH_WDATA);
        dat_rd = rd_en && !cmd_sel && (phase_q == PH_RDATA);
        op_ok  = (wdata == OP_READ) || (wdata == OP_WRITE);
        len_in = (int'(wdata) > MAX_LEN) ? IDX_W'(MAX_LEN) : IDX_W'(wdata);
        last   = (cnt_q == len_q - IDX_W'(1));
    end

    assign take_o   = cmd_wr || dat_wr;
    assign alloc_o  = dat_wr && (phase_q == PH_LEN) && is_wr_q && !hit_i;
    assign st_wr_o  = dat_wr && (phase_q == PH_WDATA);
    assign key_o    = key_q;
    assign slot_o   = slot_q;
    assign idx_o    = cnt_q[BIDX_W-1:0];
    assign hit_q_o  = hit_q;
    assign phase_o  = phase_q;
    assign gotcmd_o = gotcmd_q;
    assign done_o   = done_q;
    assign err_o    = err_q;

    // Phase sequencing; a command write always takes priority and resyncs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_IDLE;
            cnt_q    <= '0;
            len_q    <= '0;
            key_q    <= '0;
            slot_q   <= '0;
            is_wr_q  <= 1'b0;
            hit_q    <= 1'b0;
            gotcmd_q <= 1'b0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
        end else if (cmd_wr) begin
            done_q <= 1'b0;
            if (op_ok) begin
                phase_q  <= PH_KEY;
                cnt_q    <= '0;
                is_wr_q  <= (wdata == OP_WRITE);
                gotcmd_q <= 1'b1;
                err_q    <= 1'b0;
            end else begin
                phase_q  <= PH_IDLE;
                gotcmd_q <= 1'b0;
                err_q    <= 1'b1;
            end
        end else if (dat_wr) begin
            gotcmd_q <= 1'b0;
            case (phase_q)
                PH_KEY: begin
                    key_q <= {key_q[KEY_W-9:0], wdata};
                    if (cnt_q == IDX_W'(KEY_BYTES - 1)) begin
                        phase_q <= PH_LEN;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + IDX_W'(1);
                    end
                end
                PH_LEN: begin
                    len_q  <= len_in;
                    cnt_q  <= '0;
                    slot_q <= hit_i ? hit_slot_i : alloc_slot_i;
                    hit_q  <= hit_i || is_wr_q;
                    if (len_in == '0) begin
                        phase_q <= PH_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        phase_q <= is_wr_q ? PH_WDATA : PH_RDATA;
                    end
                end
                PH_WDATA: begin
                    cnt_q <= cnt_q + IDX_W'(1);
                    if (last) begin
                        phase_q <= PH_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                default: ;
            endcase
        end else if (dat_rd) begin
            cnt_q <= cnt_q + IDX_W'(1);
            if (last) begin
                phase_q <= PH_IDLE;
                done_q  <= 1'b1;
            end
        end
    end

    // R3
    closed_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (closed_i && wr_en && !rd_en) |=> ($stable(phase_q) && $stable(cnt_q) && $stable(key_q)));

    // R5
    len_clamped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(len_q) <= MAX_LEN);

    // R9
    err_means_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> (phase_q == PH_IDLE && !gotcmd_q && !done_q));

    // R6
    done_means_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (phase_q == PH_IDLE));

    // R4
    valid_cmd_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cmd_sel && !closed_i && op_ok) |=> (phase_q == PH_KEY && cnt_q == '0));
endmodule

// File: rtl/mgmt_port_engine.sv
// Management controller command/data port status engine (top).
// Decodes the two ports, assembles the status register and muxes the
// read-back byte. The hold timer, transaction FSM and key store sit below.
// Assumes the host does not assert read and write in the same cycle.
module mgmt_port_engine
    import mpe_pkg::*;
#(
    parameter int ENTRIES   = 8,
    parameter int MAX_LEN   = 32,
    parameter int KEY_BYTES = 4,
    parameter int HOLD_CYC  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic       port_sel,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic [7:0] status_o
);
    localparam int KEY_W  = 8 * KEY_BYTES;
    localparam int SLOT_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int BIDX_W = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

    logic              closed, take, alloc, st_wr, hit, hit_q, gotcmd, done, err;
    logic [KEY_W-1:0]  key;
    logic [SLOT_W-1:0] hit_slot, alloc_slot, slot;
    logic [BIDX_W-1:0] idx;
    logic [7:0]        rd_byte;
    phase_e            phase;

    mpe_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (take),
        .closed_o (closed)
    );

    mpe_txn_fsm #(.ENTRIES(ENTRIES), .MAX_LEN(MAX_LEN), .KEY_BYTES(KEY_BYTES)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .closed_i     (closed),
        .wr_en        (bus_wr),
        .rd_en        (bus_rd),
        .cmd_sel      (port_sel),
        .wdata        (bus_wdata),
        .hit_i        (hit),
        .hit_slot_i   (hit_slot),
        .alloc_slot_i (alloc_slot),
        .take_o       (take),
        .key_o        (key),
        .alloc_o      (alloc),
        .st_wr_o      (st_wr),
        .slot_o       (slot),
        .idx_o        (idx),
        .hit_q_o      (hit_q),
        .phase_o      (phase),
        .gotcmd_o     (gotcmd),
        .done_o       (done),
        .err_o        (err)
    );

    mpe_key_store #(.ENTRIES(ENTRIES), .MAX_LEN(MAX_LEN), .KEY_W(KEY_W)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .look_key_i   (key),
        .hit_o        (hit),
        .hit_slot_o   (hit_slot),
        .alloc_i      (alloc),
        .alloc_slot_o (alloc_slot),
        .wr_i         (st_wr),
        .wr_slot_i    (slot),
        .wr_idx_i     (idx),
        .wr_byte_i    (bus_wdata),
        .rd_slot_i    (slot),
        .rd_idx_i     (idx),
        .rd_byte_o    (rd_byte)
    );

    // Assemble the status register from the phase and flags
    always_comb begin
        status_o            = 8'h00;
        status_o[SB_AWAIT]  = (phase == PH_RDATA);
        status_o[SB_CLOSED] = closed;
        status_o[SB_BUSY]   = (phase != PH_IDLE);
        status_o[SB_GOTCMD] = gotcmd;
        status_o[SB_DONE]   = done;
        status_o[SB_READY]  = 1'b1;
        status_o[SB_ERR]    = err;
    end

    // Read-back mux: status on the command port, response byte on the data port
    always_comb begin
        if (port_sel)
            bus_rdata = status_o;
        else if (phase == PH_RDATA && hit_q)
            bus_rdata = rd_byte;
        else
            bus_rdata = 8'h00;
    end

    // R1
    ready_always_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[SB_READY] && !status_o[4]);

    // R8
    await_with_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[SB_AWAIT] |-> status_o[SB_BUSY]);

    // R12
    idle_data_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !port_sel && !closed && (phase == PH_IDLE || phase == PH_RDATA)) |=> !closed || (HOLD_CYC == 0) ? 1'b1 : !$rose(closed));
endmodule

// File: tb/mgmt_port_engine_bench.sv
module mgmt_port_engine_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0, port_sel = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata, status_o;

    int checks = 0, failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mgmt_port_engine #(.HOLD_CYC(HOLD)) u_mgmt_port_engine (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .port_sel(port_sel), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .status_o(status_o)
    );

    // ---------------- behavioural reference model ----------------
    // phase: 0 idle, 1 key, 2 length, 3 write payload, 4 read response
    int          m_ph, m_cnt, m_len, m_hold;
    logic [31:0] m_key;
    bit          m_wr, m_got, m_done, m_err;
    logic [7:0]  mem [logic [36:0]];
    logic [31:0] order [$];

    function automatic bit m_known(logic [31:0] k);
        foreach (order[i]) if (order[i] == k) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [7:0] m_val(logic [31:0] k, int i);
        logic [36:0] a;
        a = {k, 5'(i)};
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction

    function automatic logic [7:0] m_status();
        return {m_err, 1'b1, m_done, 1'b0, m_got, (m_ph != 0), (m_hold > 0), (m_ph == 4)};
    endfunction

    always @(posedge clk) begin
        bit cl, acc;
        int ln;
        logic [31:0] victim;
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_len = 0; m_hold = 0; m_key = '0;
            m_wr = 0; m_got = 0; m_done = 0; m_err = 0;
            mem.delete(); order.delete();
        end else begin
            cl = (m_hold > 0);
            acc = 1'b0;
            if (m_hold > 0) m_hold--;
            if (bus_wr && port_sel && !cl) begin
                acc = 1'b1;
                m_done = 0;
                if (bus_wdata == 8'h10 || bus_wdata == 8'h11) begin
                    m_ph = 1; m_cnt = 0; m_wr = (bus_wdata == 8'h11); m_got = 1; m_err = 0;
                end else begin
                    m_ph = 0; m_got = 0; m_err = 1;
                end
            end else if (bus_wr && !port_sel && !cl && m_ph >= 1 && m_ph <= 3) begin
                acc = 1'b1;
                m_got = 0;
                if (m_ph == 1) begin
                    m_key = {m_key[23:0], bus_wdata};
                    m_cnt++;
                    if (m_cnt == 4) begin m_ph = 2; m_cnt = 0; end
                end else if (m_ph == 2) begin
                    ln = (bus_wdata > 32) ? 32 : int'(bus_wdata);
                    m_len = ln; m_cnt = 0;
                    if (m_wr && !m_known(m_key)) begin
                        if (order.size() == 8) begin
                            victim = order.pop_front();
                            for (int b = 0; b < 32; b++) mem.delete({victim, 5'(b)});
                        end
                        order.push_back(m_key);
                    end
                    if (ln == 0) begin m_ph = 0; m_done = 1; end
                    else m_ph = m_wr ? 3 : 4;
                end else begin
                    mem[{m_key, 5'(m_cnt)}] = bus_wdata;
                    m_cnt++;
                    if (m_cnt == m_len) begin m_ph = 0; m_done = 1; end
                end
            end else if (bus_rd && !port_sel && m_ph == 4) begin
                m_cnt++;
                if (m_cnt == m_len) begin m_ph = 0; m_done = 1; end
            end
            if (acc) m_hold = HOLD;
        end
    end

    task automatic check(bit ok, string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%02h expected=0x%02h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare every status field and the read-back byte with the model each cycle
    always @(negedge clk) begin
        logic [7:0] es, er;
        if (rst_n && !finished) begin
            es = m_status();
            er = port_sel ? es : ((m_ph == 4) ? m_val(m_key, m_cnt) : 8'h00);
            check(status_o[6] == 1'b1 && status_o[4] == 1'b0, "R1 ready", status_o, es);
            check(status_o[1] == es[1], "R3 closed", status_o, es);
            check(status_o[2] == es[2] && status_o[5] == es[5], "R6 busy/done", status_o, es);
            check(status_o[3] == es[3], "R7 gotcmd", status_o, es);
            check(status_o[0] == es[0], "R8 await", status_o, es);
            check(status_o[7] == es[7], "R9 error", status_o, es);
            check(bus_rdata == er, port_sel ? "R2 status port" : "R10 data port", bus_rdata, er);
        end
    end

    // ---------------- stimulus ----------------
    task automatic cyc(bit w, bit r, bit s, logic [7:0] d);
        bus_wr = w; bus_rd = r; port_sel = s; bus_wdata = d;
        @(negedge clk); #1;
        bus_wr = 0; bus_rd = 0;
    endtask

    task automatic wait_open();
        while (status_o[1]) cyc(0, 0, 1, 8'h00);
    endtask

    task automatic host_wr(bit s, logic [7:0] d);
        wait_open();
        cyc(1, 0, s, d);
    endtask

    task automatic send_hdr(logic [7:0] op, logic [31:0] k, logic [7:0] ln);
        host_wr(1, op);
        for (int i = 3; i >= 0; i--) host_wr(0, k[8*i +: 8]);
        host_wr(0, ln);
    endtask

    task automatic host_rd(logic [7:0] exp, string req);
        bus_rd = 1; port_sel = 0;
        #2;
        check(bus_rdata == exp, req, bus_rdata, exp);
        @(negedge clk); #1;
        bus_rd = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            failures++; checks++;
            $display("FAIL watchdog expired");
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(status_o == 8'h40, "R1 reset status", status_o, 8'h40);
        rst_n = 1;
        @(negedge clk); #1;
        check(status_o == 8'h40, "R1 idle status", status_o, 8'h40);

        // Write key A1B2C3D4 with three bytes, then read them back (R5, R10)
        send_hdr(8'h11, 32'hA1B2C3D4, 8'd3);
        host_wr(0, 8'h11); host_wr(0, 8'h22); host_wr(0, 8'h33);
        check(status_o[2] == 1'b0 && status_o[5] == 1'b1, "R6 busy clear after last byte", status_o, 8'h62);
        send_hdr(8'h10, 32'hA1B2C3D4, 8'd3);
        check(status_o[0] && status_o[2], "R8 await with busy", status_o, 8'h45);
        host_rd(8'h11, "R10 byte0"); host_rd(8'h22, "R10 byte1"); host_rd(8'h33, "R10 byte2");
        check(status_o[0] == 1'b0 && status_o[2] == 1'b0, "R8 await clears", status_o, 8'h60);

        // Longer read than stored: tail is zero (R10)
        send_hdr(8'h10, 32'hA1B2C3D4, 8'd5);
        for (int i = 0; i < 3; i++) host_rd(8'h11 * (i + 1), "R10 stored part");
        host_rd(8'h00, "R10 unwritten tail"); host_rd(8'h00, "R10 unwritten tail");

        // Unknown key returns zeros (R10)
        send_hdr(8'h10, 32'h0BADBEEF, 8'd2);
        host_rd(8'h00, "R10 unknown key"); host_rd(8'h00, "R10 unknown key");

        // Invalid command (R9), then recovery
        host_wr(1, 8'h55);
        check(status_o == 8'hC2, "R9 invalid command", status_o, 8'hC2);
        wait_open();
        check(status_o == 8'hC0, "R9 error idle", status_o, 8'hC0);

        // Abort mid-key with a fresh command (R4)
        host_wr(1, 8'h11); host_wr(0, 8'hAA); host_wr(0, 8'hBB);
        host_wr(1, 8'h10);
        check(status_o == 8'h4E, "R4 resync status", status_o, 8'h4E);
        for (int i = 3; i >= 0; i--) host_wr(0, 8'(32'hA1B2C3D4 >> (8 * i)));
        host_wr(0, 8'd1);
        host_rd(8'h11, "R4 resync read");

        // Writes inside the closed window are dropped (R3)
        wait_open();
        cyc(1, 0, 1, 8'h10);
        cyc(1, 0, 0, 8'hEE);
        check(status_o[3] == 1'b1, "R7 gotcmd held, closed write dropped", status_o, 8'h4E);
        for (int i = 3; i >= 0; i--) host_wr(0, 8'(32'hA1B2C3D4 >> (8 * i)));
        host_wr(0, 8'd2);
        host_rd(8'h11, "R3 alignment byte0"); host_rd(8'h22, "R3 alignment byte1");

        // Data writes in idle and during read phase are ignored (R12)
        wait_open();
        cyc(1, 0, 0, 8'h77);
        check(status_o == 8'h60, "R12 idle data write", status_o, 8'h60);
        send_hdr(8'h10, 32'hA1B2C3D4, 8'd2);
        wait_open();
        cyc(1, 0, 0, 8'h99);
        check(status_o[1] == 1'b0, "R12 read-phase write no hold", status_o, 8'h45);
        host_rd(8'h11, "R12 read unaffected"); host_rd(8'h22, "R12 read unaffected");

        // Length clamp at 32 (R5)
        send_hdr(8'h11, 32'h00C0FFEE, 8'd40);
        for (int i = 0; i < 32; i++) host_wr(0, 8'(i * 3 + 1));
        check(status_o[2] == 1'b0, "R5 write clamped to 32", status_o, 8'h62);
        send_hdr(8'h10, 32'h00C0FFEE, 8'd200);
        for (int i = 0; i < 32; i++) host_rd(8'(i * 3 + 1), "R5 clamped read");
        check(status_o == 8'h60, "R5 read ends at 32", status_o, 8'h60);

        // Zero-length write ends at the length byte (R6)
        send_hdr(8'h11, 32'h12340000, 8'd0);
        check(status_o == 8'h62, "R6 zero length", status_o, 8'h62);

        // Fill past 8 keys: earliest key is replaced (R11)
        for (int i = 0; i < 6; i++) begin
            send_hdr(8'h11, 32'h50000000 + i, 8'd1);
            host_wr(0, 8'(8'hA0 + i));
        end
        send_hdr(8'h10, 32'hA1B2C3D4, 8'd1);
        host_rd(8'h00, "R11 earliest key replaced");
        send_hdr(8'h10, 32'h00C0FFEE, 8'd1);
        host_rd(8'h01, "R11 second key kept");
        send_hdr(8'h10, 32'h50000005, 8'd1);
        host_rd(8'hA5, "R11 newest key");

        // Rewrite a stored key reuses its entry (R11)
        send_hdr(8'h11, 32'h00C0FFEE, 8'd1);
        host_wr(0, 8'h5A);
        send_hdr(8'h10, 32'h50000000, 8'd1);
        host_rd(8'hA0, "R11 reuse keeps others");

        repeat (4) @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule